// File: doc/BRIEF.md
# Package Low-Power State Sequencer

This block follows the power-management state of a processor package, driven by three active-low requests from platform logic: stop-clock, sleep and deep-sleep. It walks a five-state ladder (Normal, Stop Grant, Stop Grant Snoop, Sleep, Deep Sleep). Each deeper state can be reached only from the state directly above it. Decoded outputs enable the core clock and the unit clocks, mark snoop service, and allow the pending-break indication.

While the core clock is stopped but the bus side is alive, four interrupt event lines are held in per-line pending bits instead of being serviced. They are released as one-cycle service pulses on the first cycle back in Normal. In Sleep and Deep Sleep the interrupt lines are not recognized at all. The block also measures, in bus clocks, the gap between sleep release and stop-clock release. If that gap is too short, it raises a sticky timing-violation flag.

Top module: `lps_sequencer`

## Requirements
- R1: After reset the state output is Normal and both pending and service outputs are zero; the timing flag is clear. State codes on `state_o`: 0 Normal, 1 Stop Grant, 2 Stop Grant Snoop, 3 Sleep, 4 Deep Sleep.
- R2: In Normal, a low `stop_clk_n` moves the block to Stop Grant on the next edge. In Stop Grant with `sleep_n` high, a high `stop_clk_n` returns it to Normal on the next edge.
- R3: A low `sleep_n` moves the block to Sleep only from Stop Grant. In Normal or Stop Grant Snoop it has no effect on the state. In Stop Grant it takes priority over stop-clock release and snoop.
- R4: A low `deep_n` moves the block to Deep Sleep only from Sleep and is ignored in the other states. A high `deep_n` in Deep Sleep returns it to Sleep. A high `sleep_n` in Sleep (with `deep_n` high) returns it to Stop Grant.
- R5: In Deep Sleep, every input other than `deep_n` (sleep, stop-clock, snoop, interrupt lines) has no effect. The state stays Deep Sleep and nothing is latched.
- R6: A high `snoop_req` in Stop Grant moves the block to Stop Grant Snoop, where `snoop_busy` is high. The block stays there while `snoop_req` stays high and returns to Stop Grant on the edge after it drops.
- R7: Interrupt events (`irq_evt` bit 0 SMI, bit 1 INIT, bit 2 local line 0, bit 3 local line 1) are latched in Stop Grant and Stop Grant Snoop. On the edge that enters Normal, each latched line pulses its `irq_serv` bit for exactly one cycle. An event seen in Normal pulses its bit on the next cycle.
- R8: Interrupt events seen in Sleep or Deep Sleep are dropped and produce no later service pulse.
- R9: `stop_clk_n` may be sampled high k edges after the edge that sampled the sleep release, and the block then leaves Stop Grant for Normal. If k < MIN_GAP (default 10), `gap_err` is set and stays set until reset. If k >= MIN_GAP, it stays clear.
- R10: `core_clk_en` is high only in Normal. `unit_clk_en` is low only in Sleep and Deep Sleep. `brk_allow` is high only in Stop Grant and Stop Grant Snoop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_clk_n | input | 1 | Stop-clock request, active low |
| sleep_n | input | 1 | Sleep request, active low |
| deep_n | input | 1 | Deep-sleep request, active low |
| snoop_req | input | 1 | Snoop in progress on the bus |
| irq_evt | input | N_IRQ | Interrupt event lines (SMI, INIT, local 0, local 1) |
| state_o | output | 3 | Current package state code |
| core_clk_en | output | 1 | Core clock enable |
| unit_clk_en | output | 1 | Internal unit clock enable |
| snoop_busy | output | 1 | Snoop being serviced in Stop Grant |
| brk_allow | output | 1 | Pending-break output may be driven |
| irq_serv | output | N_IRQ | One-cycle service pulse per interrupt line |
| gap_err | output | 1 | Sticky sleep-to-stop-clock spacing violation |

## Verification
The bench places stop-clock release at exactly MIN_GAP and at MIN_GAP-1 bus clocks after sleep release. An off-by-one gap counter would flag the legal case or miss the short one. It mixes interrupts latched in Stop Grant and in the snoop sub-state with interrupts pulsed in Sleep and Deep Sleep. A design that latched in the wrong states would replay dropped lines or lose held ones. It asserts sleep and deep-sleep from states where they must be ignored, and toggles every other input while in Deep Sleep. A design that skipped a rung of the ladder, or let Deep Sleep react to anything but its own release, would show a wrong state code. Finally, it checks that the violation flag survives a later correctly spaced sequence.

// File: rtl/lps_pkg.sv
package lps_pkg;
   typedef enum logic [2:0] {
      ST_NORMAL = 3'd0,
      ST_STPGNT = 3'd1,
      ST_SNOOP  = 3'd2,
      ST_SLEEP  = 3'd3,
      ST_DEEP   = 3'd4
   } lps_state_e;
endpackage

// File: rtl/lps_fsm.sv
module lps_fsm
   import lps_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_clk_n,
   input  logic       sleep_n,
   input  logic       deep_n,
   input  logic       snoop_req,
   output lps_state_e state_o,
   output lps_state_e state_nxt_o,
   output logic       wake_o,
   output logic       sleep_exit_o
);
   lps_state_e state_q, nxt;

   always_comb begin
      nxt = state_q;
      case (state_q)
         ST_NORMAL: if (!stop_clk_n) nxt = ST_STPGNT;
         ST_STPGNT: begin
            if (!sleep_n)         nxt = ST_SLEEP;
            else if (stop_clk_n)  nxt = ST_NORMAL;
            else if (snoop_req)   nxt = ST_SNOOP;
         end
         ST_SNOOP:  if (!snoop_req) nxt = ST_STPGNT;
         ST_SLEEP: begin
            if (!deep_n)          nxt = ST_DEEP;
            else if (sleep_n)     nxt = ST_STPGNT;
         end
         ST_DEEP:   if (deep_n) nxt = ST_SLEEP;
         default:   nxt = ST_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_NORMAL;
      else        state_q <= nxt;
   end

   assign state_o      = state_q;
   assign state_nxt_o  = nxt;
   assign wake_o       = (state_q == ST_STPGNT) && (nxt == ST_NORMAL);
   assign sleep_exit_o = (state_q == ST_SLEEP) && (nxt == ST_STPGNT);

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_q inside {ST_NORMAL, ST_STPGNT, ST_SNOOP, ST_SLEEP, ST_DEEP}); // R1
   AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SLEEP) |-> ($past(state_q) inside {ST_STPGNT, ST_SLEEP, ST_DEEP})); // R3
   AST_DEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEEP) |-> ($past(state_q) inside {ST_SLEEP, ST_DEEP})); // R4
   AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEEP && !deep_n) |=> (state_q == ST_DEEP)); // R5
   AST_SNOOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SNOOP) |-> ($past(state_q) inside {ST_STPGNT, ST_SNOOP})); // R6
endmodule

// File: rtl/lps_irq_hold.sv
module lps_irq_hold
   import lps_pkg::*;
#(
   parameter int N_IRQ = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lps_state_e       state_i,
   input  lps_state_e       state_nxt_i,
   input  logic [N_IRQ-1:0] evt_i,
   output logic [N_IRQ-1:0] pend_o,
   output logic [N_IRQ-1:0] serv_o
);
   logic heard, release_now;

   assign heard       = state_i inside {ST_NORMAL, ST_STPGNT, ST_SNOOP};
   assign release_now = (state_nxt_i == ST_NORMAL);

   for (genvar i = 0; i < N_IRQ; i++) begin : g_line
      logic pend_b, serv_b;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_b <= 1'b0;
            serv_b <= 1'b0;
         end else if (release_now) begin
            serv_b <= pend_b | (heard & evt_i[i]);
            pend_b <= 1'b0;
         end else begin
            serv_b <= 1'b0;
            if (heard) pend_b <= pend_b | evt_i[i];
         end
      end
      assign pend_o[i] = pend_b;
      assign serv_o[i] = serv_b;
   end

   AST_SERV_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (|serv_o) |-> (state_i == ST_NORMAL)); // R7
   AST_PEND_EMPTY_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_NORMAL) |-> (pend_o == '0)); // R7
   AST_STOPPED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i inside {ST_SLEEP, ST_DEEP}) |=> $stable(pend_o)); // R8
endmodule

// File: rtl/lps_gap_check.sv
module lps_gap_check #(
   parameter int MIN_GAP = 10,
   localparam int CW     = $clog2(MIN_GAP + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic wake_i,
   output logic err_o
);
   logic [CW-1:0] cnt_q;
   logic          armed_q, err_q;
   logic          short_gap;

   assign short_gap = armed_q && (cnt_q < CW'(MIN_GAP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         if (arm_i) begin
            cnt_q   <= CW'(1);
            armed_q <= 1'b1;
         end else if (short_gap) begin
            cnt_q   <= cnt_q + CW'(1);
         end
         if (wake_i) begin
            armed_q <= 1'b0;
            if (short_gap) err_q <= 1'b1;
         end
      end
   end

   assign err_o = err_q;

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R9
   AST_ERR_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(wake_i)); // R9
endmodule

// File: rtl/lps_sequencer.sv
module lps_sequencer
   import lps_pkg::*;
#(
   parameter int N_IRQ   = 4,
   parameter int MIN_GAP = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_clk_n,
   input  logic             sleep_n,
   input  logic             deep_n,
   input  logic             snoop_req,
   input  logic [N_IRQ-1:0] irq_evt,
   output logic [2:0]       state_o,
   output logic             core_clk_en,
   output logic             unit_clk_en,
   output logic             snoop_busy,
   output logic             brk_allow,
   output logic [N_IRQ-1:0] irq_serv,
   output logic             gap_err
);
   if (N_IRQ < 1) begin : g_bad_irq
      $error("N_IRQ must be at least 1");
   end
   if (MIN_GAP < 1) begin : g_bad_gap
      $error("MIN_GAP must be at least 1");
   end

   lps_state_e       st, st_nxt;
   logic             wake, sleep_exit;
   logic [N_IRQ-1:0] pend;

   lps_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_clk_n   (stop_clk_n),
      .sleep_n      (sleep_n),
      .deep_n       (deep_n),
      .snoop_req    (snoop_req),
      .state_o      (st),
      .state_nxt_o  (st_nxt),
      .wake_o       (wake),
      .sleep_exit_o (sleep_exit)
   );

   lps_irq_hold #(.N_IRQ(N_IRQ)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .state_i     (st),
      .state_nxt_i (st_nxt),
      .evt_i       (irq_evt),
      .pend_o      (pend),
      .serv_o      (irq_serv)
   );

   lps_gap_check #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm_i  (sleep_exit),
      .wake_i (wake),
      .err_o  (gap_err)
   );

   assign state_o     = st;
   assign core_clk_en = (st == ST_NORMAL);
   assign unit_clk_en = !(st inside {ST_SLEEP, ST_DEEP});
   assign snoop_busy  = (st == ST_SNOOP);
   assign brk_allow   = (st inside {ST_STPGNT, ST_SNOOP});

   AST_NO_PEND_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      core_clk_en |-> (pend == '0)); // R7
   AST_UNITS_OFF_NO_SERV: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_clk_en |-> (irq_serv == '0)); // R10
endmodule

// File: tb/lps_sequencer_tb.sv
`timescale 1ns/1ps
module lps_sequencer_tb_top;
   localparam int GAP = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       stop_clk_n = 1'b1, sleep_n = 1'b1, deep_n = 1'b1, snoop_req = 1'b0;
   logic [3:0] irq_evt = 4'h0;
   logic [2:0] state_o;
   logic       core_clk_en, unit_clk_en, snoop_busy, brk_allow, gap_err;
   logic [3:0] irq_serv;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lps_sequencer #(.N_IRQ(4), .MIN_GAP(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .stop_clk_n(stop_clk_n), .sleep_n(sleep_n),
      .deep_n(deep_n), .snoop_req(snoop_req), .irq_evt(irq_evt),
      .state_o(state_o), .core_clk_en(core_clk_en), .unit_clk_en(unit_clk_en),
      .snoop_busy(snoop_busy), .brk_allow(brk_allow), .irq_serv(irq_serv),
      .gap_err(gap_err)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic t_reset;
      chk("R1", "state after reset", state_o, 0);
      chk("R1", "serv after reset", irq_serv, 0);
      chk("R1", "gap flag after reset", gap_err, 0);
      chk("R10", "core clk in normal", core_clk_en, 1);
      chk("R10", "brk in normal", brk_allow, 0);
   endtask

   task automatic t_normal;
      sleep_n = 0; deep_n = 0; step(1);
      chk("R3", "sleep ignored in normal", state_o, 0);
      chk("R4", "deep ignored in normal", state_o, 0);
      sleep_n = 1; deep_n = 1;
      irq_evt = 4'b0010; step(1);
      chk("R7", "event in normal pulses", irq_serv, 4'b0010);
      irq_evt = 0; step(1);
      chk("R7", "pulse lasts one cycle", irq_serv, 0);
   endtask

   task automatic t_stopgrant;
      stop_clk_n = 0; step(1);
      chk("R2", "enter stop grant", state_o, 1);
      chk("R10", "core clk off in stop grant", core_clk_en, 0);
      chk("R10", "brk allowed in stop grant", brk_allow, 1);
      irq_evt = 4'b0101; step(1);
      irq_evt = 4'b1000; step(1);
      irq_evt = 0; step(1);
      chk("R7", "latched not serviced", irq_serv, 0);
      snoop_req = 1; step(1);
      chk("R6", "enter snoop state", state_o, 2);
      chk("R6", "snoop busy", snoop_busy, 1);
      irq_evt = 4'b0010; step(1);
      irq_evt = 0; sleep_n = 0; step(1);
      chk("R3", "sleep ignored in snoop state", state_o, 2);
      sleep_n = 1; step(1);
      chk("R6", "stays while snoop high", state_o, 2);
      snoop_req = 0; step(1);
      chk("R6", "back to stop grant", state_o, 1);
      stop_clk_n = 1; step(1);
      chk("R2", "return to normal", state_o, 0);
      chk("R7", "replay all latched", irq_serv, 4'b1111);
      step(1);
      chk("R7", "replay one cycle", irq_serv, 0);
      chk("R9", "no flag without sleep", gap_err, 0);
   endtask

   task automatic t_sleep_deep;
      stop_clk_n = 0; step(1);
      deep_n = 0; step(1);
      chk("R4", "deep ignored in stop grant", state_o, 1);
      deep_n = 1; sleep_n = 0; step(1);
      chk("R3", "enter sleep", state_o, 3);
      chk("R10", "unit clk off in sleep", unit_clk_en, 0);
      irq_evt = 4'b1111; step(1);
      irq_evt = 0; deep_n = 0; step(1);
      chk("R4", "enter deep sleep", state_o, 4);
      sleep_n = 1; stop_clk_n = 1; snoop_req = 1; irq_evt = 4'b1111; step(3);
      chk("R5", "deep ignores other inputs", state_o, 4);
      chk("R5", "no service in deep", irq_serv, 0);
      sleep_n = 0; stop_clk_n = 0; snoop_req = 0; irq_evt = 0; step(1);
      deep_n = 1; step(1);
      chk("R4", "deep release to sleep", state_o, 3);
      sleep_n = 1; step(1);
      chk("R4", "sleep release to stop grant", state_o, 1);
      step(GAP - 1);
      stop_clk_n = 1; step(1);
      chk("R9", "exact gap returns normal", state_o, 0);
      chk("R9", "exact gap no flag", gap_err, 0);
      chk("R8", "stopped events dropped", irq_serv, 0);
   endtask

   task automatic t_gap_short;
      stop_clk_n = 0; step(1);
      sleep_n = 0; step(1);
      sleep_n = 1; step(1);
      step(GAP - 2);
      stop_clk_n = 1; step(1);
      chk("R9", "short gap still wakes", state_o, 0);
      chk("R9", "short gap flagged", gap_err, 1);
      stop_clk_n = 0; step(1);
      sleep_n = 0; step(1);
      sleep_n = 1; step(1);
      step(GAP + 3);
      stop_clk_n = 1; step(1);
      chk("R9", "flag sticky", gap_err, 1);
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      t_reset();
      t_normal();
      t_stopgrant();
      t_sleep_deep();
      t_gap_short();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule